// File: doc/BRIEF.md
# Transmit Queue Frame Dequeuer

This block drains frames from a 16-bit transmit packet memory that a host fills, and turns them into a byte-wide stream toward a MAC. Frames are laid end to end in the memory, and each one begins on a word boundary. Every frame starts with a two-word header: a control word and a byte count. The data words follow the header. The block parses the header, waits until the whole frame is in memory, and sends exactly the counted number of bytes. When CRC generation is enabled, it then appends a 4-byte Ethernet CRC. Finally it moves its head pointer past the frame.

The host tells the block how many valid words lie ahead of its head pointer (`q_avail`). The block reports the head pointer back (`head_ptr`), so the host can reuse the freed space. The memory read port is combinational: `q_rd_data` is the word at `q_rd_addr` in the same cycle.

A status group reports on the frame being parsed or sent, or on the last one finished, and not on the newest frame queued. It carries the frame ID, a done flag and an error flag. An optional sticky interrupt signals that a frame has completed.

Top module: `txq_frame_dequeuer`

## Requirements
- R1: A frame at head word address H has its control word at H, its byte count at H+1, and its data from H+2. Within each data word, bits 7:0 (the lower-address byte) go out before bits 15:8. Data bytes are sent unchanged, with nothing inserted.
- R2: Control word bit 15 requests an interrupt and bits 5:0 are the frame ID. Bits 14:6 of the control word and bits 15:11 of the count word have no effect; only count bits 10:0 are used.
- R3: When `big_endian` is 1, the two bytes of both header words are swapped before they are decoded. Data bytes are never swapped.
- R4: A count of 0 or above 2000 is an error. The block sends no bytes, sets `st_err`, loads `st_fid`, raises no interrupt and advances the head by 2 words. A count of exactly 2000 is legal.
- R5: A legal frame sends exactly `count` data bytes. The next frame starts at H+2+ceil(count/2), so the pad byte of an odd count is skipped.
- R6: If `crc_en` is 1 when the header is parsed, four more bytes follow the data: the complement of the reflected CRC-32 (polynomial 0xEDB88320, initial value all ones), least significant byte first.
- R7: `tx_last` is high only on the final byte of a frame: the last data byte, or the last CRC byte when a CRC is appended.
- R8: A frame is parsed only when `q_avail` >= 2, and it is sent only once `q_avail` covers the whole frame. Until then `tx_valid` stays low.
- R9: While `tx_valid` is high and `tx_ready` is low, `tx_valid` and `tx_data` hold their values.
- R10: `st_fid` takes the frame ID and `st_done` clears when a header is parsed. `st_done` sets when that frame's last byte is accepted. These fields therefore follow the frame in progress, not later queued frames.
- R11: `irq` is a sticky flag. It becomes 1 in the cycle after the final byte of a frame with bit 15 set is accepted. `irq_clr` clears it, and a set in the same cycle wins over the clear.
- R12: During and after reset: `tx_valid`, `tx_last`, `irq`, `st_done` and `st_err` are 0, and `st_fid` and `head_ptr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| crc_en | input | 1 | Append a generated CRC to frames parsed while set |
| big_endian | input | 1 | Swap header bytes before decoding |
| q_avail | input | AW+1 | Valid words ahead of head_ptr |
| q_rd_addr | output | AW | Packet memory word address |
| q_rd_data | input | 16 | Word at q_rd_addr, same cycle |
| head_ptr | output | AW | Word address of the next frame header |
| tx_data | output | 8 | Outgoing byte |
| tx_valid | output | 1 | tx_data is valid |
| tx_last | output | 1 | Final byte of the frame |
| tx_ready | input | 1 | MAC accepts the byte this cycle |
| st_fid | output | 6 | Frame ID of the current or latest frame |
| st_done | output | 1 | That frame has been fully sent |
| st_err | output | 1 | That frame was dropped for a bad count |
| irq | output | 1 | Sticky completion interrupt |
| irq_clr | input | 1 | Write-one-to-clear for irq |

## Verification
Several properties are checked on every cycle by the assertions:
- the output holds under back-pressure;
- the number of bytes in each completed frame matches its count, plus four when a CRC is appended;
- no byte goes out while the error flag is up;
- the interrupt and the done flag rise only after a final-byte handshake;
- streaming never starts before the whole frame is available.

Other behaviours can only be shown by the bench's scenarios: byte order, header byte swapping, CRC values, skipping of pad bytes, and the status following an in-flight frame while a second frame waits behind it.

// File: rtl/txq_frame_dequeuer.sv
module txq_frame_dequeuer #(
  parameter int AW   = 11,
  parameter int MAXB = 2000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          crc_en,
  input  logic          big_endian,
  input  logic [AW:0]   q_avail,
  output logic [AW-1:0] q_rd_addr,
  input  logic [15:0]   q_rd_data,
  output logic [AW-1:0] head_ptr,
  output logic [7:0]    tx_data,
  output logic          tx_valid,
  output logic          tx_last,
  input  logic          tx_ready,
  output logic [5:0]    st_fid,
  output logic          st_done,
  output logic          st_err,
  output logic          irq,
  input  logic          irq_clr
);
  localparam int BW = 11;

  typedef enum logic [2:0] {S_IDLE, S_HDR, S_WAIT, S_DATA, S_CRC} st_t;
  st_t state;

  logic [AW-1:0] head;
  logic [6:0]    ctrl_q;
  logic [BW-1:0] bc, idx;
  logic [1:0]    k;
  logic [31:0]   crc;
  logic          crc_on;
  logic [BW:0]   sent_q;

  wire [15:0]   hdr     = big_endian ? {q_rd_data[7:0], q_rd_data[15:8]} : q_rd_data;
  wire          hdr_unused = ^hdr[14:6];
  wire [BW-1:0] hdr_bc  = hdr[10:0];
  wire          bad_bc  = (hdr_bc == '0) || (32'(hdr_bc) > MAXB);
  wire [BW:0]   nwords  = (BW+1)'(2) + (({1'b0, bc} + (BW+1)'(1)) >> 1);
  wire          last_dt = (idx == bc - BW'(1));
  wire [31:0]   crc_inv = ~crc;
  wire          fire    = tx_valid && tx_ready;
  wire          end_fire = fire && tx_last;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c ^ {24'h0, d};
    for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction

  assign head_ptr = head;
  assign tx_valid = (state == S_DATA) || (state == S_CRC);
  assign tx_last  = (state == S_DATA && last_dt && !crc_on) || (state == S_CRC && k == 2'd3);

  always_comb begin
    case (state)
      S_IDLE:  q_rd_addr = head;
      S_HDR:   q_rd_addr = head + AW'(1);
      default: q_rd_addr = head + AW'(2) + AW'(idx >> 1);
    endcase
    if (state == S_CRC) tx_data = 8'(crc_inv >> {k, 3'b000});
    else                tx_data = idx[0] ? q_rd_data[15:8] : q_rd_data[7:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; head <= '0; ctrl_q <= '0; bc <= '0; idx <= '0; k <= '0;
      crc <= '1; crc_on <= 1'b0; st_fid <= '0; st_done <= 1'b0; st_err <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (32'(q_avail) >= 2) begin
          ctrl_q <= {hdr[15], hdr[5:0]};
          state  <= S_HDR;
        end
        S_HDR: begin
          st_fid  <= ctrl_q[5:0];
          st_done <= 1'b0;
          if (bad_bc) begin
            st_err <= 1'b1;
            head   <= head + AW'(2);
            state  <= S_IDLE;
          end else begin
            st_err <= 1'b0;
            bc     <= hdr_bc;
            idx    <= '0;
            k      <= '0;
            crc    <= '1;
            crc_on <= crc_en;
            state  <= S_WAIT;
          end
        end
        S_WAIT: if (32'(q_avail) >= 32'(nwords)) state <= S_DATA;
        S_DATA: if (fire) begin
          crc <= crc_step(crc, tx_data);
          idx <= idx + BW'(1);
          if (last_dt) begin
            if (crc_on) state <= S_CRC;
            else begin
              head <= head + AW'(nwords); st_done <= 1'b1; state <= S_IDLE;
            end
          end
        end
        S_CRC: if (fire) begin
          k <= k + 2'd1;
          if (k == 2'd3) begin
            head <= head + AW'(nwords); st_done <= 1'b1; state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      irq <= 1'b0;
    else if (end_fire && ctrl_q[6])  irq <= 1'b1;
    else if (irq_clr)                irq <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sent_q <= '0;
    else if (end_fire) sent_q <= '0;
    else if (fire)     sent_q <= sent_q + (BW+1)'(1);
  end

  a_r9_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));
  a_r5_byte_total: assert property (@(posedge clk) disable iff (!rst_n)
    end_fire |-> (32'(sent_q) + 1 == 32'(bc) + (crc_on ? 4 : 0)));
  a_r4_no_tx_on_error: assert property (@(posedge clk) disable iff (!rst_n)
    st_err |-> !tx_valid);
  a_r11_irq_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(end_fire));
  a_r10_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_done) |-> $past(end_fire));
  a_r8_whole_frame_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_valid) |-> $past(32'(q_avail) >= 32'(nwords)));
endmodule

// File: tb/sim_txq_frame_dequeuer.sv
`timescale 1ns/1ps
module sim_txq_frame_dequeuer;
  localparam int AW = 11;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic crc_en = 1'b0, big_endian = 1'b0, irq_clr = 1'b0, tx_ready = 1'b1;
  logic [AW:0] q_avail;
  logic [AW-1:0] q_rd_addr, head_ptr, wp;
  logic [15:0] q_rd_data;
  logic [7:0] tx_data;
  logic tx_valid, tx_last, st_done, st_err, irq;
  logic [5:0] st_fid;
  logic [15:0] mem [0:2047];

  assign q_rd_data = mem[q_rd_addr];
  assign q_avail   = {1'b0, wp - head_ptr};

  txq_frame_dequeuer #(.AW(AW), .MAXB(2000)) u0 (
    .clk(clk), .rst_n(rst_n), .crc_en(crc_en), .big_endian(big_endian),
    .q_avail(q_avail), .q_rd_addr(q_rd_addr), .q_rd_data(q_rd_data), .head_ptr(head_ptr),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_last(tx_last), .tx_ready(tx_ready),
    .st_fid(st_fid), .st_done(st_done), .st_err(st_err), .irq(irq), .irq_clr(irq_clr));

  // fields: [31] irq request, [30] big-endian, [29] crc, [27:22] frame ID, [10:0] count
  localparam logic [31:0] VEC [6] = '{
    {1'b1, 1'b0, 1'b0, 1'b0, 6'd5,  11'd0, 11'd60},
    {1'b0, 1'b0, 1'b1, 1'b0, 6'd33, 11'd0, 11'd64},
    {1'b1, 1'b1, 1'b0, 1'b0, 6'd63, 11'd0, 11'd17},
    {1'b1, 1'b1, 1'b1, 1'b0, 6'd0,  11'd0, 11'd1},
    {1'b0, 1'b0, 1'b0, 1'b0, 6'd12, 11'd0, 11'd2},
    {1'b1, 1'b0, 1'b1, 1'b0, 6'd40, 11'd0, 11'd123}};

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [7:0] expb [0:4095];
  logic [7:0] got  [0:4095];
  int exp_n = 0, got_n = 0, last_pos = -1, last_cnt = 0, irq_at_last = -1, irq_after = -1;
  int stall_viol = 0;
  bit pend_irq = 0, prev_stall = 0, rdy_rand = 0;
  logic [7:0] prev_data = '0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    tx_ready = rdy_rand ? (lfsr[0] | lfsr[3]) : 1'b1;
  end

  always @(negedge clk) if (rst_n) begin
    if (pend_irq) begin irq_after = int'(irq); pend_irq = 0; end
    if (tx_valid && prev_stall && tx_data != prev_data) stall_viol++;
    prev_stall = tx_valid && !tx_ready;
    prev_data  = tx_data;
    if (tx_valid && tx_ready) begin
      got[got_n] = tx_data;
      if (tx_last) begin
        last_pos = got_n; last_cnt++; irq_at_last = int'(irq); pend_irq = 1;
      end
      got_n++;
    end
  end

  function automatic logic [7:0] pat(int v, int i);
    return 8'(v * 37 + i * 13 + 5);
  endfunction

  function automatic logic [15:0] swp(logic [15:0] w, logic be);
    return be ? {w[7:0], w[15:8]} : w;
  endfunction

  task automatic put(logic [15:0] w);
    mem[wp] = w;
    wp = wp + 1'b1;
  endtask

  task automatic push_hdr(logic irqr, logic [5:0] fid, logic [10:0] bc, logic be, logic junk);
    put(swp({irqr, junk ? 9'h1A5 : 9'h000, fid}, be));
    put(swp({junk ? 5'h15 : 5'h00, bc}, be));
  endtask

  task automatic push_data(int v, int bc);
    for (int i = 0; i < bc; i += 2)
      put({(i + 1 < bc) ? pat(v, i + 1) : 8'hEE, pat(v, i)});
  endtask

  task automatic add_exp(int v, int bc, bit crc);
    int start;
    logic [31:0] c;
    bit fb;
    start = exp_n;
    for (int i = 0; i < bc; i++) begin expb[exp_n] = pat(v, i); exp_n++; end
    if (crc) begin
      c = 32'hFFFF_FFFF;
      for (int j = start; j < exp_n; j++)
        for (int b = 0; b < 8; b++) begin
          fb = c[0] ^ expb[j][b];
          c = c >> 1;
          if (fb) c = c ^ 32'hEDB8_8320;
        end
      c = ~c;
      for (int b = 0; b < 4; b++) begin expb[exp_n] = c[8*b +: 8]; exp_n++; end
    end
  endtask

  task automatic clear_rx();
    got_n = 0; exp_n = 0; last_cnt = 0; last_pos = -1; irq_at_last = -1; irq_after = -1;
  endtask

  task automatic wait_head(logic [AW-1:0] target, string req);
    int n = 0;
    while (head_ptr != target && n < 20000) begin @(negedge clk); n++; end
    check(head_ptr == target, req, int'(head_ptr), int'(target));
    repeat (3) @(negedge clk);
  endtask

  task automatic cmp_bytes(string req);
    int bad = 0;
    check(got_n == exp_n, req, got_n, exp_n);
    for (int i = 0; i < exp_n; i++) if (got[i] !== expb[i]) bad++;
    check(bad == 0, req, bad, 0);
  endtask

  task automatic pulse_clr();
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
  endtask

  initial begin
    wp = '0;
    for (int i = 0; i < 2048; i++) mem[i] = 16'h0;
    repeat (4) @(negedge clk);
    // R12 reset values
    check(!tx_valid && !tx_last && !irq && !st_done && !st_err, "R12", int'(tx_valid), 0);
    check(st_fid == 0 && head_ptr == 0, "R12", int'(head_ptr), 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check(!tx_valid && head_ptr == 0, "R8 empty queue idle", int'(tx_valid), 0);

    foreach (VEC[v]) begin
      logic irqr, be, crc;
      logic [5:0] fid;
      int bc;
      string req;
      irqr = VEC[v][31]; be = VEC[v][30]; crc = VEC[v][29];
      fid = VEC[v][27:22]; bc = int'(VEC[v][10:0]);
      req = crc ? "R6" : (be ? "R3" : "R1");
      rdy_rand = v[0];
      crc_en = crc; big_endian = be;
      pulse_clr();
      clear_rx();
      add_exp(v, bc, crc);
      push_hdr(irqr, fid, 11'(bc), be, v[0]);   // R2: odd vectors carry junk reserved bits
      push_data(v, bc);
      wait_head(wp, "R5 next frame address");
      cmp_bytes(req);
      check(last_cnt == 1 && last_pos == exp_n - 1, "R7", last_pos, exp_n - 1);
      check(st_fid == fid && st_done && !st_err, "R2/R10 status", int'(st_fid), int'(fid));
      check(irq_at_last == 0 && irq_after == int'(irqr), "R11", irq_after, int'(irqr));
    end
    check(stall_viol == 0, "R9", stall_viol, 0);

    check(irq == 1'b1, "R11 sticky", int'(irq), 1);
    pulse_clr();
    @(negedge clk);
    check(irq == 1'b0, "R11 clear", int'(irq), 0);

    rdy_rand = 0; crc_en = 0; big_endian = 0;
    clear_rx();
    push_hdr(1'b1, 6'd21, 11'd0, 1'b0, 1'b0);
    wait_head(wp, "R4 zero count skip");
    check(st_err && st_fid == 21 && !st_done, "R4 zero count", int'(st_fid), 21);
    check(got_n == 0 && !irq, "R4 zero count silent", got_n, 0);

    push_hdr(1'b1, 6'd22, 11'd2001, 1'b0, 1'b0);
    wait_head(wp, "R4 oversize skip");
    check(st_err && st_fid == 22 && got_n == 0 && !irq, "R4 oversize", got_n, 0);

    clear_rx();
    add_exp(23, 2000, 1'b0);
    push_hdr(1'b0, 6'd23, 11'd2000, 1'b0, 1'b0);
    push_data(23, 2000);
    wait_head(wp, "R4 max count");
    cmp_bytes("R4 max count");
    check(!st_err && st_done && st_fid == 23, "R4 max status", int'(st_err), 0);

    clear_rx();
    push_hdr(1'b0, 6'd30, 11'd10, 1'b0, 1'b0);
    repeat (30) @(negedge clk);
    check(got_n == 0 && !tx_valid, "R8 partial frame", got_n, 0);
    check(st_fid == 30 && !st_done, "R10 header parsed", int'(st_fid), 30);
    add_exp(30, 10, 1'b0);
    push_data(30, 10);
    wait_head(wp, "R8 completed frame");
    cmp_bytes("R8");

    begin
      int n = 0;
      clear_rx();
      add_exp(40, 40, 1'b0);
      push_hdr(1'b0, 6'd7, 11'd40, 1'b0, 1'b0);
      push_data(40, 40);
      add_exp(41, 30, 1'b0);
      push_hdr(1'b0, 6'd9, 11'd30, 1'b0, 1'b0);
      push_data(41, 30);
      while (got_n < 20 && n < 2000) begin @(negedge clk); n++; end
      check(st_fid == 7 && !st_done, "R10 in-flight frame", int'(st_fid), 7);
      wait_head(wp, "R10 queue drained");
      check(st_fid == 9 && st_done, "R10 latest frame", int'(st_fid), 9);
      cmp_bytes("R10 back to back");
      check(last_cnt == 2, "R7 two frames", last_cnt, 2);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule